// File: doc/BRIEF.md
# Mark-Ratio Quasi-Random Bit Stream Generator

This block produces a serial test stream of one bit per clock from a maximal-length linear feedback shift register. Seven trinomials can be selected, giving periods of 2^n−1 bits for n of 7, 9, 11, 15, 20, 23 or 31. Besides the plain stream, with about half of its bits set, it can shape the stream into a quasi-random stream. Such a stream has a lower or higher density of ones and is used to stress receivers. The shaping ANDs two or three register stages and, for the high-density settings, inverts the result.

The stages that are ANDed lie one position apart or three positions apart. Both spacings give the same count of ones per period but different local bit patterns. A one-clock marker flags the first bit of each period, so a checker or scope can align to the pattern. Reset, or any change of the polynomial select, reloads the all-ones seed. This keeps the register out of the all-zero lock-up state.

Top module: `prbs_mr_gen`

## Requirements
- R1: The register has stages 1..n. Each step shifts stage k into stage k+1, and stage 1 receives stage n XOR stage a for the polynomial 1+x^a+x^n. The polynomial select takes these codes: 0 → (a=6,n=7), 1 → (5,9), 2 → (9,11), 3 → (14,15), 4 → (3,20), 5 → (18,23), 6 → (28,31), 7 → same as 0. With ratio code 0 (density 1/2), dataOut is stage n and the stream repeats every 2^n−1 steps.
- R2: While rstN is low the register holds all ones, dataOut is 1 at ratio code 0, and periodStart is 0. After release, the first output is the seed output with periodStart high.
- R3: periodStart is high for exactly one clock when the register holds the all-ones seed of the current polynomial and the block steps. It is never high in two consecutive clocks and never high while enable is low.
- R4: While enable is low the register does not advance, dataOut holds its value and periodStart stays low. When enable returns, the sequence continues from where it stopped.
- R5: Ratio code 1 (density 1/4) drives dataOut with stage n AND stage n−k, where k is 1 when shiftSel is 0 and 3 when shiftSel is 1. This gives 2^(n−2) ones per period.
- R6: Ratio code 2 (density 1/8) drives dataOut with stage n AND stage n−k AND stage n−2k. This gives 2^(n−3) ones per period.
- R7: Ratio code 3 (density 3/4) is the inverse of the code 1 output, and ratio code 4 (density 7/8) is the inverse of the code 2 output. Codes 5 to 7 act as code 0.
- R8: At density 1/4 with one-position spacing, the stream never contains the bits 1,0,1 in a row. With three-position spacing it does, for n=7.
- R9: A change of polySel reloads the seed at the next clock edge, which steps nothing. In the clock after that, periodStart is high if enable is high, and the new period is counted from there.
- R10: For n=7 at density 1/2, one period holds 64 ones and 63 zeros. Its longest run of ones is 7 bits and its longest run of zeros is 6 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low; loads the seed |
| enable | input | 1 | Advance the register by one stage per clock when high |
| polySel | input | 3 | Polynomial code (see R1) |
| ratioSel | input | 3 | Ones-density code (see R1, R5–R7) |
| shiftSel | input | 1 | Stage spacing for the AND: 0 one position, 1 three positions |
| dataOut | output | 1 | Serial pattern bit |
| periodStart | output | 1 | One-clock marker on the first bit of each period |

## Verification
The main function is driven with every density code at both spacings on the 7-stage polynomial. It is also driven with the 9-, 11- and 15-stage polynomials over one full period, and with the 23- and 31-stage polynomials over their first few hundred bits. Comparing each bit against an independent model separates errors in the feedback taps from errors in stage selection. The per-period ones count tells an AND of two stages from an AND of three, and a direct output from an inverted one. The presence or absence of the 1,0,1 pattern tells the two spacings apart, which the ones count cannot do. The marker spacing after reset, after a hold on enable and after a polynomial change shows where the seed is reloaded and where stepping resumes.

// File: rtl/prbs_mr_pkg.sv
`timescale 1ns/1ps
package prbs_mr_pkg;

  localparam int MaxOrder = 31;
  localparam int OrderW   = $clog2(MaxOrder + 1);
  localparam int PolySelW = 3;
  localparam int RatioW   = 3;

  typedef enum logic [RatioW-1:0] {
    RatioHalf       = 3'd0,
    RatioQuarter    = 3'd1,
    RatioEighth     = 3'd2,
    RatioThreeQuart = 3'd3,
    RatioSevenEight = 3'd4
  } ratio_e;

  typedef struct packed {
    logic load;
    logic step;
  } ctrl_t;

  typedef struct packed {
    logic [OrderW-1:0] order;
    logic [OrderW-1:0] tap;
  } poly_t;

  function automatic poly_t polyLookup(input logic [PolySelW-1:0] sel);
    poly_t p;
    case (sel)
      3'd1:    p = '{order: OrderW'(9),  tap: OrderW'(5)};
      3'd2:    p = '{order: OrderW'(11), tap: OrderW'(9)};
      3'd3:    p = '{order: OrderW'(15), tap: OrderW'(14)};
      3'd4:    p = '{order: OrderW'(20), tap: OrderW'(3)};
      3'd5:    p = '{order: OrderW'(23), tap: OrderW'(18)};
      3'd6:    p = '{order: OrderW'(31), tap: OrderW'(28)};
      default: p = '{order: OrderW'(7),  tap: OrderW'(6)};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/prbs_mr_ctrl.sv
`timescale 1ns/1ps
module prbs_mr_ctrl
  import prbs_mr_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic [PolySelW-1:0] polySel,
  output ctrl_t               ctrl,
  output logic [PolySelW-1:0] polyCur
);

  logic [PolySelW-1:0] polyQ;
  logic                loadReq;

  // Tracks the select every clock, also during reset, so that the
  // first cycle after reset never sees a spurious change.
  always_ff @(posedge clk) begin
    polyQ <= polySel;
  end

  assign loadReq = (polySel != polyQ);
  assign ctrl    = '{load: loadReq, step: rstN & enable & ~loadReq};
  assign polyCur = polyQ;

endmodule

// File: rtl/prbs_mr_dp.sv
`timescale 1ns/1ps
module prbs_mr_dp
  import prbs_mr_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_t               ctrl,
  input  logic [PolySelW-1:0] polyCur,
  input  logic [RatioW-1:0]   ratioSel,
  input  logic                shiftSel,
  output logic                dataOut,
  output logic                periodStart
);

  // state[k-1] is stage k
  logic [MaxOrder-1:0] state;
  logic [MaxOrder-1:0] orderMask;
  poly_t               cfg;
  logic [OrderW-1:0]   idxTop, idxTap, idxMid, idxLow, spacing;
  logic                feedback, atSeed;
  logic                tapHi, tapMid, tapLo, andTwo, andThree;

  assign cfg = polyLookup(polyCur);

  for (genvar g = 0; g < MaxOrder; g++) begin : gMask
    assign orderMask[g] = (OrderW'(g) < cfg.order);
  end

  assign spacing  = shiftSel ? OrderW'(3) : OrderW'(1);
  assign idxTop   = cfg.order - OrderW'(1);
  assign idxTap   = cfg.tap - OrderW'(1);
  assign idxMid   = idxTop - spacing;
  assign idxLow   = idxMid - spacing;
  assign feedback = state[idxTop] ^ state[idxTap];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= '1;
    end else if (ctrl.load) begin
      state <= '1;
    end else if (ctrl.step) begin
      state <= {state[MaxOrder-2:0], feedback};
    end
  end

  assign atSeed   = &(state | ~orderMask);
  assign tapHi    = state[idxTop];
  assign tapMid   = state[idxMid];
  assign tapLo    = state[idxLow];
  assign andTwo   = tapHi & tapMid;
  assign andThree = andTwo & tapLo;

  always_comb begin
    case (ratio_e'(ratioSel))
      RatioQuarter:    dataOut = andTwo;
      RatioEighth:     dataOut = andThree;
      RatioThreeQuart: dataOut = ~andTwo;
      RatioSevenEight: dataOut = ~andThree;
      default:         dataOut = tapHi;
    endcase
  end

  assign periodStart = ctrl.step & atSeed;

endmodule

// File: rtl/prbs_mr_gen.sv
`timescale 1ns/1ps
module prbs_mr_gen
  import prbs_mr_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic [PolySelW-1:0] polySel,
  input  logic [RatioW-1:0]   ratioSel,
  input  logic                shiftSel,
  output logic                dataOut,
  output logic                periodStart
);

  ctrl_t               ctrl;
  logic [PolySelW-1:0] polyCur;

  prbs_mr_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .polySel (polySel),
    .ctrl    (ctrl),
    .polyCur (polyCur)
  );

  prbs_mr_dp i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .polyCur     (polyCur),
    .ratioSel    (ratioSel),
    .shiftSel    (shiftSel),
    .dataOut     (dataOut),
    .periodStart (periodStart)
  );

endmodule

// File: rtl/prbs_mr_chk.sv
`timescale 1ns/1ps
module prbs_mr_chk
  import prbs_mr_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                enable,
  input logic [PolySelW-1:0] polySel,
  input logic [RatioW-1:0]   ratioSel,
  input logic                shiftSel,
  input logic                dataOut,
  input logic                periodStart
);

  logic [1:0] sinceReset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceReset <= '0;
    else if (sinceReset != 2'd3) sinceReset <= sinceReset + 2'd1;
  end

  a_r3_marker_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    periodStart |-> enable);

  a_r3_marker_single: assert property (@(posedge clk) disable iff (!rstN)
    periodStart |=> !periodStart);

  a_r9_restart_after_change: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(polySel) |=> (($stable(polySel) && enable) |-> periodStart));

  // R8: three consecutive stepped bits at density 1/4, one-position spacing
  a_r8_no_one_zero_one: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset == 2'd3 &&
     ratioSel == 3'd1 && $past(ratioSel) == 3'd1 && $past(ratioSel, 2) == 3'd1 &&
     !shiftSel && !$past(shiftSel) && !$past(shiftSel, 2) &&
     $past(enable) && $past(enable, 2) &&
     $stable(polySel) && $past(polySel) == $past(polySel, 2) &&
     $past(polySel, 2) == $past(polySel, 3) &&
     $past(dataOut, 2) && !$past(dataOut)) |-> !dataOut);

endmodule

bind prbs_mr_gen prbs_mr_chk i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .enable      (enable),
  .polySel     (polySel),
  .ratioSel    (ratioSel),
  .shiftSel    (shiftSel),
  .dataOut     (dataOut),
  .periodStart (periodStart)
);

// File: tb/test_prbs_mr_gen.sv
`timescale 1ns/1ps
module test_prbs_mr_gen;

  localparam int ClkPeriod = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [2:0] polySel = 3'd0;
  logic [2:0] ratioSel = 3'd0;
  logic       shiftSel = 1'b0;
  logic       dataOut, periodStart;

  prbs_mr_gen i_prbs_mr_gen (
    .clk(clk), .rstN(rstN), .enable(enable), .polySel(polySel),
    .ratioSel(ratioSel), .shiftSel(shiftSel),
    .dataOut(dataOut), .periodStart(periodStart)
  );

  always #(ClkPeriod/2) clk = ~clk;

  typedef struct packed {
    logic [2:0]  poly;
    logic [2:0]  ratio;
    logic        shift;
    logic [15:0] period;
    logic [15:0] ones;
  } vec_t;

  localparam int NumVec = 14;
  localparam vec_t Vecs [NumVec] = '{
    '{3'd0, 3'd0, 1'b0, 16'd127,   16'd64},
    '{3'd0, 3'd1, 1'b0, 16'd127,   16'd32},
    '{3'd0, 3'd1, 1'b1, 16'd127,   16'd32},
    '{3'd0, 3'd2, 1'b0, 16'd127,   16'd16},
    '{3'd0, 3'd2, 1'b1, 16'd127,   16'd16},
    '{3'd0, 3'd3, 1'b0, 16'd127,   16'd95},
    '{3'd0, 3'd3, 1'b1, 16'd127,   16'd95},
    '{3'd0, 3'd4, 1'b0, 16'd127,   16'd111},
    '{3'd0, 3'd4, 1'b1, 16'd127,   16'd111},
    '{3'd1, 3'd0, 1'b0, 16'd511,   16'd256},
    '{3'd1, 3'd2, 1'b1, 16'd511,   16'd64},
    '{3'd2, 3'd0, 1'b0, 16'd2047,  16'd1024},
    '{3'd2, 3'd3, 1'b1, 16'd2047,  16'd1535},
    '{3'd3, 3'd0, 1'b0, 16'd32767, 16'd16384}
  };

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  // independent reference register: ms[k-1] is stage k
  logic [30:0] ms;
  int mOrd, mTap;

  // statistics of the last measured period
  int lastOnes, lastMism, lastStray, max1, max0, cnt101;
  bit startMark, endMark;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string ratioTag(input logic [2:0] r);
    case (r)
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3, 3'd4: return "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic modelSeed(input logic [2:0] p);
    case (p)
      3'd1: begin mOrd = 9;  mTap = 5;  end
      3'd2: begin mOrd = 11; mTap = 9;  end
      3'd3: begin mOrd = 15; mTap = 14; end
      3'd4: begin mOrd = 20; mTap = 3;  end
      3'd5: begin mOrd = 23; mTap = 18; end
      3'd6: begin mOrd = 31; mTap = 28; end
      default: begin mOrd = 7; mTap = 6; end
    endcase
    ms = '1;
  endtask

  task automatic modelStep();
    ms = {ms[29:0], ms[mOrd-1] ^ ms[mTap-1]};
  endtask

  function automatic logic modelBit(input logic [2:0] r, input logic s);
    int k;
    logic hi, mid, lo;
    k = s ? 3 : 1;
    hi = ms[mOrd-1];
    mid = ms[mOrd-1-k];
    lo = ms[mOrd-1-2*k];
    case (r)
      3'd1: return hi & mid;
      3'd2: return hi & mid & lo;
      3'd3: return ~(hi & mid);
      3'd4: return ~(hi & mid & lo);
      default: return hi;
    endcase
  endfunction

  // all drives happen at a falling edge; the release leaves the outputs
  // showing the seed until the next rising edge
  task automatic applyReset(input logic [2:0] p, input logic [2:0] r, input logic s);
    @(negedge clk);
    rstN = 1'b0; enable = 1'b1;
    polySel = p; ratioSel = r; shiftSel = s;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    modelSeed(p);
  endtask

  task automatic runPeriod(input int period, input logic [2:0] r, input logic s);
    int run1, run0;
    logic prev1, prev2;
    lastOnes = 0; lastMism = 0; lastStray = 0;
    max1 = 0; max0 = 0; cnt101 = 0; run1 = 0; run0 = 0;
    prev1 = 1'b0; prev2 = 1'b0;
    for (int i = 0; i < period; i++) begin
      #1;
      if (i == 0) startMark = periodStart;
      else if (periodStart) lastStray++;
      if (dataOut !== modelBit(r, s)) lastMism++;
      if (dataOut) begin
        lastOnes++; run1++; run0 = 0;
        if (run1 > max1) max1 = run1;
      end else begin
        run0++; run1 = 0;
        if (run0 > max0) max0 = run0;
      end
      if (i >= 2 && prev2 && !prev1 && dataOut) cnt101++;
      prev2 = prev1; prev1 = dataOut;
      modelStep();
      @(negedge clk);
    end
    #1 endMark = periodStart;
  endtask

  initial begin
    #(ClkPeriod * 200000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL all requirements watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    // R2: state during reset
    @(negedge clk);
    rstN = 1'b0; enable = 1'b1; polySel = 3'd0; ratioSel = 3'd0; shiftSel = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    check(periodStart == 1'b0, "R2", "marker in reset", periodStart, 0);
    check(dataOut == 1'b1, "R2", "data in reset", dataOut, 1);

    // table of full-period vectors
    for (int v = 0; v < NumVec; v++) begin
      applyReset(Vecs[v].poly, Vecs[v].ratio, Vecs[v].shift);
      runPeriod(int'(Vecs[v].period), Vecs[v].ratio, Vecs[v].shift);
      check(startMark == 1'b1, "R2", $sformatf("vec %0d first marker", v), startMark, 1);
      check(lastStray == 0, "R3", $sformatf("vec %0d stray markers", v), lastStray, 0);
      check(endMark == 1'b1, "R1", $sformatf("vec %0d marker after period", v), endMark, 1);
      check(lastOnes == int'(Vecs[v].ones), ratioTag(Vecs[v].ratio),
            $sformatf("vec %0d ones per period", v), lastOnes, Vecs[v].ones);
      check(lastMism == 0, ratioTag(Vecs[v].ratio),
            $sformatf("vec %0d bits differing from model", v), lastMism, 0);
      if (v == 0) begin
        check(max1 == 7, "R10", "longest ones run", max1, 7);
        check(max0 == 6, "R10", "longest zeros run", max0, 6);
      end
      if (Vecs[v].ratio == 3'd1 && Vecs[v].poly == 3'd0) begin
        if (!Vecs[v].shift) check(cnt101 == 0, "R8", "101 count, one-position", cnt101, 0);
        else check(cnt101 > 0, "R8", "101 count, three-position (expect >0)", cnt101, 1);
      end
    end

    // R4: hold while enable is low
    begin
      int stray, moved, j;
      logic held;
      applyReset(3'd0, 3'd0, 1'b0);
      for (int i = 0; i < 10; i++) begin
        #1; modelStep(); @(negedge clk);
      end
      enable = 1'b0;
      #1 held = dataOut;
      stray = 0; moved = 0;
      for (int i = 0; i < 20; i++) begin
        #1;
        if (periodStart) stray++;
        if (dataOut !== held) moved++;
        @(negedge clk);
      end
      check(stray == 0, "R4", "markers while disabled", stray, 0);
      check(moved == 0, "R4", "data changes while disabled", moved, 0);
      check(held == modelBit(3'd0, 1'b0), "R4", "held bit", held, modelBit(3'd0, 1'b0));
      enable = 1'b1;
      j = 0;
      for (int i = 0; i < 300; i++) begin
        #1;
        if (periodStart) break;
        j++;
        @(negedge clk);
      end
      check(j == 117, "R4", "steps to next marker after resume", j, 117);
    end

    // R9: polynomial change restarts from the seed
    applyReset(3'd0, 3'd0, 1'b0);
    for (int i = 0; i < 30; i++) begin
      #1; @(negedge clk);
    end
    polySel = 3'd1;
    #1;
    check(periodStart == 1'b0, "R9", "marker in reload cycle", periodStart, 0);
    @(negedge clk);
    modelSeed(3'd1);
    runPeriod(511, 3'd0, 1'b0);
    check(startMark == 1'b1, "R9", "marker after change", startMark, 1);
    check(endMark == 1'b1 && lastStray == 0, "R9", "new period length marker", endMark, 1);
    check(lastMism == 0, "R9", "bits after change vs model", lastMism, 0);

    // R1: long polynomials, first bits against the model
    applyReset(3'd5, 3'd0, 1'b0);
    runPeriod(300, 3'd0, 1'b0);
    check(lastMism == 0, "R1", "order 23 bits vs model", lastMism, 0);
    applyReset(3'd6, 3'd4, 1'b1);
    runPeriod(300, 3'd4, 1'b1);
    check(lastMism == 0, "R7", "order 31 density 7/8 bits vs model", lastMism, 0);
    applyReset(3'd7, 3'd6, 1'b0);
    runPeriod(127, 3'd0, 1'b0);
    check(lastMism == 0 && endMark == 1'b1, "R7", "spare codes act as defaults", lastMism, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule